// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register store of a processor core: sixteen 32-bit registers, two combinational read ports and one write port, all working on the register set of the current processor mode. Registers 8 to 14 are shadowed by bank. The fast-interrupt bank keeps a private copy of all seven. The other privileged banks keep private copies of 13 and 14 only. An unrecognised mode code selects a dummy bank in which 8 to 14 read as zero. When a mode change moves the core to a different bank, the outgoing registers are saved and the incoming ones are restored on one clock edge.

A side port reads or writes any register as it is seen from a named mode, without changing the current mode. A separate port reads or writes the saved-status word of a named mode. Each of the five exception banks owns one saved-status word. Banks that have none answer a read with the current status word, which arrives on an input, and they ignore a write.

Top module: `rf_banked`

## Requirements
- R1: The 5-bit mode maps to a bank as follows. 0x00, 0x10 and 0x1F select user. 0x01 and 0x11 select fast-interrupt. 0x02 and 0x12 select interrupt. 0x03 and 0x13 select supervisor. 0x17 selects abort and 0x1B selects undefined. Every other code selects the dummy bank.
- R2: Reset sets the current mode to 0x13 and clears every register, bank copy and saved-status word. A mode-change request loads `newMode` into `curMode` on the next edge. Without a request, `curMode` holds its value.
- R3: Both read ports return the live register selected by their address in the same cycle. A write through the main port is visible from the next cycle onward.
- R4: On entry to fast-interrupt from any other bank, live r8–r12 are saved into the user copies and r13–r14 into the old bank. All of r8–r14 are then restored from the fast-interrupt copies. On exit from fast-interrupt, r8–r14 are saved into its copies and r8–r12 are restored from the user copies.
- R5: A change between the user, interrupt, supervisor, abort and undefined banks saves and restores only r13 and r14. r8–r12 keep their values.
- R6: Entering the dummy bank forces live r8–r14 to zero. Leaving it saves nothing, and the target bank is restored as in R4 and R5. r0–r7 and r15 are never touched by a swap.
- R7: A mode change whose old and new codes map to the same bank (for example user 0x10 and system 0x1F) moves no register.
- R8: A main-port write in the same cycle as a mode change lands in the outgoing mode's register before that register is saved.
- R9: A side access to r0–r7 or r15, or to any register in the current bank, goes to the live register. An access to r8–r14 of another bank goes to that bank's stored copy. While the fast-interrupt bank is live, r8–r12 of other banks resolve to the user copies. Side reads from the dummy bank return zero and side writes to it are ignored.
- R10: Each of fast-interrupt, interrupt, supervisor, abort and undefined has its own saved-status word, read and written by naming any mode of that bank. For the user and dummy banks a read returns `statusIn` and a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data from the live set |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data from the live set |
| wrEn | input | 1 | Main write enable |
| wrAddr | input | 4 | Main write register number |
| wrData | input | 32 | Main write data |
| modeChg | input | 1 | Mode-change request |
| newMode | input | 5 | Mode taken on a request |
| curMode | output | 5 | Current mode |
| sideMode | input | 5 | Mode through which the side port views the registers |
| sideAddr | input | 4 | Side port register number |
| sideWrEn | input | 1 | Side port write enable |
| sideWrData | input | 32 | Side port write data |
| sideRdData | output | 32 | Side port read data |
| psrMode | input | 5 | Mode whose saved-status word is accessed |
| psrWrEn | input | 1 | Saved-status write enable |
| psrWrData | input | 32 | Saved-status write data |
| psrRdData | output | 32 | Saved-status read data |
| statusIn | input | 32 | Current status word, returned for banks without a saved word |

## Verification
The swap logic is driven through every kind of transition:

- user to the same-bank system code;
- into and out of fast-interrupt;
- between two privileged banks that share r8–r12;
- into and out of the dummy bank.

Each registers' values are distinct, so a save to the wrong copy or a missed restore shows up as a wrong value. A write issued together with a mode change, and then read back through the side port, tells apart a write that lands before the save from one that lands after it. Side-port and saved-status accesses through the alias codes (0x01 against 0x11, 0x03 against 0x13) and through undefined codes exercise the mode-to-bank decode on its own.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NUM_REGS  = 16;
  localparam int REG_AW    = 4;
  localparam int MODE_W    = 5;
  localparam int BANK_LO   = 8;            // first shadowed register
  localparam int SHADOW_N  = 7;            // r8..r14
  localparam int FIQ_ONLY  = 5;            // r8..r12 private to fast-interrupt
  localparam int NUM_BANKS = 8;
  localparam int IDX_W     = $clog2(SHADOW_N);

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_DMY = 3'd7
  } bank_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              swap;
    bank_e             oldBank;
    bank_e             newBank;
    logic              sideLive;
    logic              sideShValid;
    bank_e             sideShBank;
    logic [IDX_W-1:0]  sideIdx;
    logic [REG_AW-1:0] sideAddr;
    logic              psrHas;
    bank_e             psrBank;
  } rfCtl_t;

  function automatic bank_e modeToBank(input logic [MODE_W-1:0] m);
    case (m)
      5'h00, 5'h10, 5'h1F: modeToBank = BK_USR;
      5'h01, 5'h11:        modeToBank = BK_FIQ;
      5'h02, 5'h12:        modeToBank = BK_IRQ;
      5'h03, 5'h13:        modeToBank = BK_SVC;
      5'h17:               modeToBank = BK_ABT;
      5'h1B:               modeToBank = BK_UND;
      default:             modeToBank = BK_DMY;
    endcase
  endfunction

  function automatic logic bankHasPsr(input bank_e b);
    bankHasPsr = (b != BK_USR) && (b != BK_DMY);
  endfunction
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import rf_pkg::*;
#(
  parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeChg,
  input  logic [MODE_W-1:0] newMode,
  input  logic [MODE_W-1:0] sideMode,
  input  logic [REG_AW-1:0] sideAddr,
  input  logic [MODE_W-1:0] psrMode,
  output logic [MODE_W-1:0] curMode,
  output rfCtl_t            ctl
);
  logic [MODE_W-1:0] modeQ;
  bank_e curBank, nextBank, sideBank;
  logic [REG_AW-1:0] sideOff;
  logic sideBanked, sideLowGroup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       modeQ <= RST_MODE;
    else if (modeChg) modeQ <= newMode;
  end

  assign curMode = modeQ;

  always_comb begin
    curBank      = modeToBank(modeQ);
    nextBank     = modeToBank(newMode);
    sideBank     = modeToBank(sideMode);
    sideOff      = sideAddr - REG_AW'(BANK_LO);
    sideBanked   = (int'(sideAddr) >= BANK_LO) && (int'(sideAddr) < BANK_LO + SHADOW_N);
    sideLowGroup = int'(sideOff) < FIQ_ONLY;

    ctl             = '0;
    ctl.swap        = modeChg && (nextBank != curBank);
    ctl.oldBank     = curBank;
    ctl.newBank     = nextBank;
    ctl.sideAddr    = sideAddr;
    ctl.sideIdx     = sideOff[IDX_W-1:0];
    ctl.sideShBank  = sideBank;
    ctl.psrBank     = modeToBank(psrMode);
    ctl.psrHas      = bankHasPsr(ctl.psrBank);

    if (!sideBanked || sideBank == curBank) begin
      ctl.sideLive = 1'b1;
    end else if (sideBank == BK_DMY) begin
      ctl.sideLive    = 1'b0;   // dummy copies read zero
      ctl.sideShValid = 1'b0;
    end else if (!sideLowGroup || sideBank == BK_FIQ) begin
      ctl.sideShValid = 1'b1;
    end else if (curBank == BK_FIQ) begin
      ctl.sideShValid = 1'b1;
      ctl.sideShBank  = BK_USR;  // r8-r12 parked in user copies
    end else begin
      ctl.sideLive = 1'b1;       // r8-r12 shared with live set
    end
  end
endmodule

// File: rtl/rf_bank_data.sv
module rf_bank_data
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rfCtl_t            ctl,
  input  logic [REG_AW-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sideWrEn,
  input  logic [DATA_W-1:0] sideWrData,
  output logic [DATA_W-1:0] sideRdData,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrWrData,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] psrRdData
);
  logic [DATA_W-1:0] live    [NUM_REGS];
  logic [DATA_W-1:0] shadow  [NUM_BANKS][SHADOW_N];
  logic [DATA_W-1:0] psr     [NUM_BANKS];
  logic [DATA_W-1:0] liveN   [NUM_REGS];
  logic [DATA_W-1:0] shadowN [NUM_BANKS][SHADOW_N];
  logic [DATA_W-1:0] psrN    [NUM_BANKS];

  assign rdDataA    = live[rdAddrA];
  assign rdDataB    = live[rdAddrB];
  assign sideRdData = ctl.sideLive    ? live[ctl.sideAddr] :
                      ctl.sideShValid ? shadow[ctl.sideShBank][ctl.sideIdx] : '0;
  assign psrRdData  = ctl.psrHas ? psr[ctl.psrBank] : statusIn;

  always_comb begin
    liveN   = live;
    shadowN = shadow;
    psrN    = psr;

    // side write first, main write overrides on the same live register
    if (sideWrEn) begin
      if (ctl.sideLive)         liveN[ctl.sideAddr] = sideWrData;
      else if (ctl.sideShValid) shadowN[ctl.sideShBank][ctl.sideIdx] = sideWrData;
    end
    if (wrEn) liveN[wrAddr] = wrData;
    if (psrWrEn && ctl.psrHas) psrN[ctl.psrBank] = psrWrData;

    if (ctl.swap) begin
      // save outgoing set (post-write values)
      for (int i = 0; i < SHADOW_N; i++) begin
        if (ctl.oldBank == BK_FIQ)
          shadowN[BK_FIQ][i] = liveN[BANK_LO+i];
        else if (ctl.oldBank != BK_DMY) begin
          if (i >= FIQ_ONLY)
            shadowN[ctl.oldBank][i] = liveN[BANK_LO+i];
          else if (ctl.newBank == BK_FIQ)
            shadowN[BK_USR][i] = liveN[BANK_LO+i];
        end
      end
      // restore incoming set
      for (int i = 0; i < SHADOW_N; i++) begin
        if (ctl.newBank == BK_FIQ)
          liveN[BANK_LO+i] = shadowN[BK_FIQ][i];
        else if (ctl.newBank == BK_DMY)
          liveN[BANK_LO+i] = '0;
        else if (i >= FIQ_ONLY)
          liveN[BANK_LO+i] = shadowN[ctl.newBank][i];
        else if (ctl.oldBank == BK_FIQ)
          liveN[BANK_LO+i] = shadowN[BK_USR][i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) live[r] <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        psr[b] <= '0;
        for (int i = 0; i < SHADOW_N; i++) shadow[b][i] <= '0;
      end
    end else begin
      live   <= liveN;
      shadow <= shadowN;
      psr    <= psrN;
    end
  end
endmodule

// File: rtl/rf_banked.sv
module rf_banked
  import rf_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              modeChg,
  input  logic [MODE_W-1:0] newMode,
  output logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] sideMode,
  input  logic [REG_AW-1:0] sideAddr,
  input  logic              sideWrEn,
  input  logic [DATA_W-1:0] sideWrData,
  output logic [DATA_W-1:0] sideRdData,
  input  logic [MODE_W-1:0] psrMode,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrWrData,
  output logic [DATA_W-1:0] psrRdData,
  input  logic [DATA_W-1:0] statusIn
);
  rfCtl_t ctl;

  rf_bank_ctrl #(.RST_MODE(RST_MODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeChg(modeChg), .newMode(newMode),
    .sideMode(sideMode), .sideAddr(sideAddr), .psrMode(psrMode),
    .curMode(curMode), .ctl(ctl)
  );

  rf_bank_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sideWrEn(sideWrEn), .sideWrData(sideWrData), .sideRdData(sideRdData),
    .psrWrEn(psrWrEn), .psrWrData(psrWrData), .statusIn(statusIn),
    .psrRdData(psrRdData)
  );
endmodule

// File: rtl/rf_banked_chk.sv
module rf_banked_chk
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              modeChg,
  input logic [MODE_W-1:0] newMode,
  input logic [MODE_W-1:0] curMode,
  input logic [REG_AW-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [MODE_W-1:0] sideMode,
  input logic [REG_AW-1:0] sideAddr,
  input logic [DATA_W-1:0] sideRdData,
  input logic [MODE_W-1:0] psrMode,
  input logic [DATA_W-1:0] psrRdData,
  input logic [DATA_W-1:0] statusIn
);
  logic enterDummy;
  assign enterDummy = modeChg && modeToBank(newMode) == BK_DMY && modeToBank(curMode) != BK_DMY;

  a_r2_mode_follow: assert property (@(posedge clk) disable iff (!rst_n)
    modeChg |=> curMode == $past(newMode));

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !modeChg |=> $stable(curMode));

  a_r6_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    enterDummy && int'(rdAddrA) >= BANK_LO && int'(rdAddrA) < BANK_LO + SHADOW_N
    |=> $stable(rdAddrA) |-> rdDataA == '0);

  a_r9_unbanked_live: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sideAddr) < BANK_LO || int'(sideAddr) == NUM_REGS - 1) && rdAddrA == sideAddr
    |-> sideRdData == rdDataA);

  a_r9_same_bank_live: assert property (@(posedge clk) disable iff (!rst_n)
    modeToBank(sideMode) == modeToBank(curMode) && rdAddrA == sideAddr
    |-> sideRdData == rdDataA);

  a_r10_no_psr_status: assert property (@(posedge clk) disable iff (!rst_n)
    (modeToBank(psrMode) == BK_USR || modeToBank(psrMode) == BK_DMY)
    |-> psrRdData == statusIn);
endmodule

bind rf_banked rf_banked_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .modeChg(modeChg), .newMode(newMode),
  .curMode(curMode), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .sideMode(sideMode), .sideAddr(sideAddr), .sideRdData(sideRdData),
  .psrMode(psrMode), .psrRdData(psrRdData), .statusIn(statusIn)
);

// File: tb/rf_banked_test.sv
module rf_banked_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [3:0]  rdAddrA, rdAddrB, wrAddr, sideAddr;
  logic [31:0] rdDataA, rdDataB, wrData, sideWrData, sideRdData;
  logic [31:0] psrWrData, psrRdData, statusIn;
  logic        wrEn, modeChg, sideWrEn, psrWrEn;
  logic [4:0]  newMode, curMode, sideMode, psrMode;

  int total = 0;
  int bad = 0;

  localparam logic [31:0] STAT = 32'hC0DE_5A5A;

  rf_banked uut (
    .clk(clk), .rst_n(rst_n),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modeChg(modeChg), .newMode(newMode), .curMode(curMode),
    .sideMode(sideMode), .sideAddr(sideAddr), .sideWrEn(sideWrEn),
    .sideWrData(sideWrData), .sideRdData(sideRdData),
    .psrMode(psrMode), .psrWrEn(psrWrEn), .psrWrData(psrWrData),
    .psrRdData(psrRdData), .statusIn(statusIn)
  );

  localparam logic [3:0] OP_RD = 0, OP_WR = 1, OP_MC = 2, OP_WM = 3, OP_SRD = 4,
                         OP_SWR = 5, OP_PW = 6, OP_PRD = 7, OP_CM = 8;

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  mode;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VECS [NV] = '{
    '{OP_MC,  5'h10, 4'd0,  32'h0,         4'd5},  // R5 svc->user
    '{OP_CM,  5'h00, 4'd0,  32'h10,        4'd2},  // R2
    '{OP_RD,  5'h00, 4'd13, 32'h0,         4'd5},  // R5
    '{OP_RD,  5'h00, 4'd8,  32'h1008,      4'd5},  // R5 r8 kept
    '{OP_WR,  5'h00, 4'd13, 32'hAAAA0013,  4'd3},  // R3
    '{OP_WR,  5'h00, 4'd14, 32'hAAAA0014,  4'd3},
    '{OP_WR,  5'h00, 4'd8,  32'hAAAA0008,  4'd3},
    '{OP_RD,  5'h00, 4'd8,  32'hAAAA0008,  4'd3},  // R3
    '{OP_MC,  5'h1F, 4'd0,  32'h0,         4'd7},  // R7 user->system
    '{OP_RD,  5'h00, 4'd13, 32'hAAAA0013,  4'd7},
    '{OP_RD,  5'h00, 4'd14, 32'hAAAA0014,  4'd7},
    '{OP_MC,  5'h11, 4'd0,  32'h0,         4'd4},  // R4 enter fiq
    '{OP_RD,  5'h00, 4'd8,  32'h0,         4'd4},
    '{OP_RD,  5'h00, 4'd13, 32'h0,         4'd4},
    '{OP_RD,  5'h00, 4'd12, 32'h0,         4'd4},
    '{OP_SRD, 5'h10, 4'd8,  32'hAAAA0008,  4'd9},  // R9 user copy
    '{OP_SRD, 5'h13, 4'd13, 32'h100D,      4'd9},  // R9 svc copy
    '{OP_SRD, 5'h11, 4'd8,  32'h0,         4'd9},  // R9 same bank
    '{OP_SRD, 5'h10, 4'd3,  32'h1003,      4'd9},  // R9 unbanked
    '{OP_WR,  5'h00, 4'd8,  32'hF8F80008,  4'd4},
    '{OP_WR,  5'h00, 4'd14, 32'hF8F8000E,  4'd4},
    '{OP_WM,  5'h12, 4'd9,  32'hF8F80009,  4'd8},  // R8 write+leave fiq
    '{OP_RD,  5'h00, 4'd9,  32'h1009,      4'd4},  // R4 user r9 back
    '{OP_RD,  5'h00, 4'd8,  32'hAAAA0008,  4'd4},
    '{OP_RD,  5'h00, 4'd14, 32'h0,         4'd5},
    '{OP_SRD, 5'h11, 4'd9,  32'hF8F80009,  4'd8},  // R8
    '{OP_SRD, 5'h11, 4'd14, 32'hF8F8000E,  4'd4},
    '{OP_SWR, 5'h13, 4'd14, 32'h5555000E,  4'd9},  // R9 write svc copy
    '{OP_SRD, 5'h13, 4'd14, 32'h5555000E,  4'd9},
    '{OP_MC,  5'h13, 4'd0,  32'h0,         4'd5},  // R5 irq->svc
    '{OP_RD,  5'h00, 4'd14, 32'h5555000E,  4'd9},
    '{OP_RD,  5'h00, 4'd13, 32'h100D,      4'd5},
    '{OP_PW,  5'h13, 4'd0,  32'hD3,        4'd10}, // R10
    '{OP_PRD, 5'h13, 4'd0,  32'hD3,        4'd10},
    '{OP_PW,  5'h10, 4'd0,  32'h1234,      4'd10},
    '{OP_PRD, 5'h10, 4'd0,  STAT,          4'd10},
    '{OP_PRD, 5'h1F, 4'd0,  STAT,          4'd10},
    '{OP_PW,  5'h17, 4'd0,  32'h97,        4'd10},
    '{OP_PRD, 5'h17, 4'd0,  32'h97,        4'd10},
    '{OP_PRD, 5'h1B, 4'd0,  32'h0,         4'd10},
    '{OP_MC,  5'h05, 4'd0,  32'h0,         4'd6},  // R6 enter dummy
    '{OP_CM,  5'h00, 4'd0,  32'h05,        4'd2},
    '{OP_RD,  5'h00, 4'd8,  32'h0,         4'd6},
    '{OP_RD,  5'h00, 4'd14, 32'h0,         4'd6},
    '{OP_RD,  5'h00, 4'd7,  32'h1007,      4'd6},
    '{OP_WR,  5'h00, 4'd10, 32'hDEAD000A,  4'd6},
    '{OP_MC,  5'h17, 4'd0,  32'h0,         4'd6},  // R6 leave dummy
    '{OP_RD,  5'h00, 4'd10, 32'hDEAD000A,  4'd6},
    '{OP_RD,  5'h00, 4'd13, 32'h0,         4'd6},
    '{OP_SRD, 5'h07, 4'd13, 32'h0,         4'd9},  // R9 dummy view
    '{OP_SWR, 5'h07, 4'd13, 32'h1,         4'd9},
    '{OP_SRD, 5'h07, 4'd13, 32'h0,         4'd9},
    '{OP_PW,  5'h01, 4'd0,  32'h11,        4'd1},  // R1 alias codes
    '{OP_PRD, 5'h11, 4'd0,  32'h11,        4'd1},
    '{OP_PW,  5'h02, 4'd0,  32'h22,        4'd1},
    '{OP_PRD, 5'h12, 4'd0,  32'h22,        4'd1},
    '{OP_PRD, 5'h03, 4'd0,  32'hD3,        4'd1},
    '{OP_PW,  5'h1B, 4'd0,  32'h9B,        4'd1},
    '{OP_PRD, 5'h1B, 4'd0,  32'h9B,        4'd1},
    '{OP_PRD, 5'h16, 4'd0,  STAT,          4'd1},
    '{OP_MC,  5'h00, 4'd0,  32'h0,         4'd5},  // R5 abort->user
    '{OP_RD,  5'h00, 4'd13, 32'hAAAA0013,  4'd5},
    '{OP_RD,  5'h00, 4'd10, 32'hDEAD000A,  4'd5},
    '{OP_RD,  5'h00, 4'd9,  32'h0,         4'd6}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; modeChg = 0; sideWrEn = 0; psrWrEn = 0;
  endtask

  task automatic runStep(input vec_t v);
    @(negedge clk);
    idle();
    case (v.op)
      OP_RD:  begin rdAddrA = v.addr; rdAddrB = v.addr; end
      OP_WR:  begin wrEn = 1; wrAddr = v.addr; wrData = v.data; end
      OP_MC:  begin modeChg = 1; newMode = v.mode; end
      OP_WM:  begin modeChg = 1; newMode = v.mode; wrEn = 1; wrAddr = v.addr; wrData = v.data; end
      OP_SRD: begin sideMode = v.mode; sideAddr = v.addr; end
      OP_SWR: begin sideMode = v.mode; sideAddr = v.addr; sideWrEn = 1; sideWrData = v.data; end
      OP_PW:  begin psrMode = v.mode; psrWrEn = 1; psrWrData = v.data; end
      OP_PRD: psrMode = v.mode;
      default: ;
    endcase
    #1;
    case (v.op)
      OP_RD: begin
        check(int'(v.req), rdDataA, v.data, "read port A");
        check(int'(v.req), rdDataB, v.data, "read port B");
      end
      OP_SRD: check(int'(v.req), sideRdData, v.data, "side read");
      OP_PRD: check(int'(v.req), psrRdData, v.data, "saved status read");
      OP_CM:  check(int'(v.req), {27'd0, curMode}, v.data, "current mode");
      default: ;
    endcase
    @(posedge clk);
  endtask

  initial begin
    idle();
    rdAddrA = 0; rdAddrB = 0; wrAddr = 0; wrData = 0; newMode = 5'h13;
    sideMode = 5'h13; sideAddr = 0; sideWrData = 0; psrMode = 5'h13;
    psrWrData = 0; statusIn = STAT;
    repeat (3) @(posedge clk);
    #1;
    // R2 reset state
    check(2, {27'd0, curMode}, 32'h13, "reset mode");
    check(2, psrRdData, 32'h0, "reset saved status");
    check(3, rdDataA, 32'h0, "reset r0");
    @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      wrEn = 1; wrAddr = 4'(r); wrData = 32'h1000 + r;
      @(posedge clk);
    end
    @(negedge clk);
    idle();
    rdAddrA = 4'd2; rdAddrB = 4'd15;
    #1;
    check(3, rdDataA, 32'h1002, "port A r2");   // R3
    check(3, rdDataB, 32'h100F, "port B r15");  // R3
    for (int k = 0; k < NV; k++) runStep(VECS[k]);
    // R2 reset mid-run clears state
    @(negedge clk);
    idle();
    rst_n = 0; rdAddrA = 4'd13; psrMode = 5'h17;
    #1;
    check(2, {27'd0, curMode}, 32'h13, "mode after reset");
    check(2, rdDataA, 32'h0, "r13 after reset");
    check(2, psrRdData, 32'h0, "saved status after reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule